// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block is the host-side master for a 12-bit differential successive-approximation converter with a three-wire serial link. It divides the system clock to produce the serial clock. It drives the active-low chip select and samples the converter's data line on every serial-clock rising edge. It drops the four leading null bits of each conversion and presents the result as a signed 12-bit two's complement word with a one-cycle valid strobe. Each conversion takes sixteen serial clocks. The conversion starts when chip select falls, and the result bits come most significant first.

A single start pulse launches a run of one or more frames. Within one frame, chip select can stay low for several back-to-back conversions. Between frames, chip select goes high for a programmable idle time, and the serial clock is parked high. Short cycling is chosen by keeping fewer than twelve result bits. In that case chip select is released right after the last wanted bit, and the word is reported left-aligned with a partial flag. The four null bits are also checked. A one in any of them raises a framing-error flag on that word.

Top module: `sard_ctrl`

## Requirements
- R1: After reset and whenever no run is active, `adc_cs_n` is 1, `adc_sclk` is 1, `busy` is 0 and `res_valid` is 0.
- R2: Every level of `adc_sclk` inside a frame lasts exactly HALF_DIV system clocks. `adc_cs_n` falls only while `adc_sclk` is high, and the first falling edge follows HALF_DIV system clocks later.
- R3: A full conversion spans 16 `adc_sclk` rising edges, and `adc_dout` is sampled on each of them. Rising edges 1 to 4 carry null bits. Edges 5 to 16 carry result bits 11 down to 0. The result appears on `res_data` as 12-bit two's complement (7FF positive full scale, 800 negative full scale, 000 zero) with `res_valid` high for exactly one cycle.
- R4: With `cfg_keep` selecting 12 bits, `cfg_words` conversions (0 treated as 1) run back to back under one chip-select low period, each with 16 rising edges and no extra clock between them, and each reports its own result.
- R5: `cfg_keep` values 1 to 11 select short cycling, with one conversion per frame regardless of `cfg_words`. Chip select rises one half period after rising edge 4+keep. The result holds the received bits in its top positions, the unreceived low bits are zero, and `res_partial` is 1. Values 0 and 13 to 15 mean 12 bits, and full results have `res_partial` at 0.
- R6: `res_frame_err` is 1 on a result exactly when at least one of that conversion's four null bits was sampled as 1.
- R7: A run has `cfg_frames` frames (0 treated as 1). After each frame, chip select stays high for (`cfg_idle`+1)×HALF_DIV system clocks with `adc_sclk` held high, and `busy` falls after the last such interval.
- R8: A `start` pulse while `busy` is 1 is ignored. The run keeps its frame and result counts.
- R9: The configuration is captured when `start` is accepted. Changing `cfg_*` during a run does not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches a run when idle |
| cfg_keep | input | 4 | Result bits to keep (1..12, others mean 12) |
| cfg_words | input | WORDS_W | Conversions per frame for full-width reads |
| cfg_frames | input | FRAMES_W | Frames per run |
| cfg_idle | input | IDLE_W | Extra half periods of chip-select high between frames |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter, parked high |
| busy | output | 1 | A run is in progress |
| res_data | output | 12 | Signed result, left-aligned when partial |
| res_valid | output | 1 | One-cycle strobe for res_data and flags |
| res_partial | output | 1 | Result was short-cycled |
| res_frame_err | output | 1 | A null bit of this conversion was 1 |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that `adc_dout` changes only on serial-clock falling edges and so is steady when the controller samples it half a period later. The bench's converter model follows this: it updates the data line only on the falling edges of `adc_sclk` while chip select is low, and it picks a new code at the first fall of each conversion. Configuration changes and the extra start pulse are applied mid-run, on system-clock falling edges, to check that they are ignored. The sweep covers every keep width, several word and frame counts, and injected null-bit errors. The codes include both full-scale values, zero and minus one.

// File: rtl/sard_pkg.sv
package sard_pkg;
  localparam int RES_W     = 12;
  localparam int NULL_W    = 4;
  localparam int CONV_CLKS = NULL_W + RES_W;
  localparam int IDX_W     = $clog2(CONV_CLKS);
  localparam int KEEP_W    = $clog2(RES_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_GAP
  } seq_st_t;

  // keep value outside 1..RES_W selects a full-width read
  function automatic logic [KEEP_W-1:0] keep_norm(input logic [KEEP_W-1:0] k);
    if (k == '0 || int'(k) > RES_W) return KEEP_W'(RES_W);
    return k;
  endfunction

  // rising-edge index (0-based) that carries the last wanted bit
  function automatic logic [IDX_W-1:0] last_idx(input logic [KEEP_W-1:0] k);
    return IDX_W'(NULL_W - 1 + int'(k));
  endfunction

  function automatic logic [RES_W-1:0] left_align(input logic [RES_W-1:0] raw,
                                                  input logic [KEEP_W-1:0] k);
    return raw << (RES_W - int'(k));
  endfunction

  // bits below the kept field
  function automatic logic [RES_W-1:0] low_mask(input logic [KEEP_W-1:0] k);
    return ~({RES_W{1'b1}} << (RES_W - int'(k)));
  endfunction
endpackage

// File: rtl/sard_tick.sv
module sard_tick #(
  parameter int HALF_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (int'(cnt_q) == HALF_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sard_seq.sv
module sard_seq
  import sard_pkg::*;
#(
  parameter int HALF_DIV = 8,
  parameter int WORDS_W  = 4,
  parameter int FRAMES_W = 4,
  parameter int IDLE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [KEEP_W-1:0]   cfg_keep,
  input  logic [WORDS_W-1:0]  cfg_words,
  input  logic [FRAMES_W-1:0] cfg_frames,
  input  logic [IDLE_W-1:0]   cfg_idle,
  input  logic                tick,
  output logic                run,
  output logic                busy,
  output logic                cs_n,
  output logic                sclk,
  output logic                rise_evt,
  output logic                word_last,
  output logic [IDX_W-1:0]    bit_idx,
  output logic [KEEP_W-1:0]   keep_q
);
  seq_st_t             st_q;
  logic [WORDS_W-1:0]  words_q, word_n;
  logic [FRAMES_W-1:0] frames_q, frame_n;
  logic [IDLE_W-1:0]   idle_q, gap_n;
  logic                done_q;
  logic [KEEP_W-1:0]   keep_in;
  logic                more_words;
  logic                gap_done;

  assign keep_in    = keep_norm(cfg_keep);
  assign run        = (st_q != ST_IDLE);
  assign busy       = run;
  assign rise_evt   = (st_q == ST_LOW) && tick;
  assign word_last  = rise_evt && (bit_idx == last_idx(keep_q));
  assign more_words = (int'(word_n) + 1) < int'(words_q);
  assign gap_done   = (st_q == ST_GAP) && tick && (gap_n == idle_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      bit_idx  <= '0;
      done_q   <= 1'b0;
      word_n   <= '0;
      frame_n  <= '0;
      gap_n    <= '0;
      keep_q   <= KEEP_W'(RES_W);
      words_q  <= WORDS_W'(1);
      frames_q <= FRAMES_W'(1);
      idle_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          keep_q   <= keep_in;
          words_q  <= (int'(keep_in) != RES_W || cfg_words == '0) ? WORDS_W'(1) : cfg_words;
          frames_q <= (cfg_frames == '0) ? FRAMES_W'(1) : cfg_frames;
          idle_q   <= cfg_idle;
          word_n   <= '0;
          frame_n  <= '0;
          bit_idx  <= '0;
          done_q   <= 1'b0;
          cs_n     <= 1'b0;
          st_q     <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          sclk <= 1'b0;
          st_q <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sclk <= 1'b1;
          st_q <= ST_HIGH;
          if (word_last) begin
            done_q  <= 1'b1;
            bit_idx <= '0;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_HIGH: if (tick) begin
          if (done_q) begin
            done_q <= 1'b0;
            if (more_words) begin
              word_n <= word_n + 1'b1;
              sclk   <= 1'b0;
              st_q   <= ST_LOW;
            end else begin
              word_n  <= '0;
              frame_n <= frame_n + 1'b1;
              gap_n   <= '0;
              cs_n    <= 1'b1;
              st_q    <= ST_GAP;
            end
          end else begin
            sclk <= 1'b0;
            st_q <= ST_LOW;
          end
        end
        ST_GAP: if (tick) begin
          if (gap_done) begin
            if (frame_n == frames_q) begin
              st_q <= ST_IDLE;
            end else begin
              cs_n <= 1'b0;
              st_q <= ST_LEAD;
            end
          end else begin
            gap_n <= gap_n + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // half-period watcher for the assertions
  localparam int HP_W = $clog2(HALF_DIV + 1) + 1;
  logic            sclk_d;
  logic [HP_W-1:0] hp_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      hp_cnt <= '1;
    end else begin
      sclk_d <= sclk;
      if (sclk != sclk_d)  hp_cnt <= '0;
      else if (hp_cnt != '1) hp_cnt <= hp_cnt + 1'b1;
    end
  end

  a_r2_cs_falls_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk);
  a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_d) |-> (int'(hp_cnt) >= HALF_DIV - 1));
  a_r7_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && sclk));
  a_r3_sample_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> !cs_n);
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(keep_q) && $stable(words_q) && $stable(idle_q)));
endmodule

// File: rtl/sard_capture.sv
module sard_capture
  import sard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              word_last,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [KEEP_W-1:0] keep_q,
  input  logic              dout,
  output logic [RES_W-1:0]  res_data,
  output logic              res_valid,
  output logic              res_partial,
  output logic              res_ferr
);
  logic [RES_W-1:0] sh_q, sh_n;
  logic             err_q, err_n;
  logic             first, is_null;

  assign first   = (bit_idx == '0);
  assign is_null = (int'(bit_idx) < NULL_W);

  always_comb begin
    err_n = (first ? 1'b0 : err_q) | (is_null & dout);
    if (is_null) sh_n = first ? '0 : sh_q;
    else         sh_n = {sh_q[RES_W-2:0], dout};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q        <= '0;
      err_q       <= 1'b0;
      res_data    <= '0;
      res_valid   <= 1'b0;
      res_partial <= 1'b0;
      res_ferr    <= 1'b0;
    end else begin
      res_valid <= word_last;
      if (rise_evt) begin
        sh_q  <= sh_n;
        err_q <= err_n;
      end
      if (word_last) begin
        res_data    <= left_align(sh_n, keep_q);
        res_partial <= (int'(keep_q) < RES_W);
        res_ferr    <= err_n;
      end
    end
  end

  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_data & low_mask(keep_q)) == '0));
  a_r5_partial_flag: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_partial == (int'(keep_q) != RES_W)));
endmodule

// File: rtl/sard_ctrl.sv
module sard_ctrl
  import sard_pkg::*;
#(
  parameter int HALF_DIV = 8,
  parameter int WORDS_W  = 4,
  parameter int FRAMES_W = 4,
  parameter int IDLE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          cfg_keep,
  input  logic [WORDS_W-1:0]  cfg_words,
  input  logic [FRAMES_W-1:0] cfg_frames,
  input  logic [IDLE_W-1:0]   cfg_idle,
  input  logic                adc_dout,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                busy,
  output logic [11:0]         res_data,
  output logic                res_valid,
  output logic                res_partial,
  output logic                res_frame_err
);
  logic              run, tick, rise_evt, word_last;
  logic [IDX_W-1:0]  bit_idx;
  logic [KEEP_W-1:0] keep_q;

  sard_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  sard_seq #(
    .HALF_DIV(HALF_DIV), .WORDS_W(WORDS_W), .FRAMES_W(FRAMES_W), .IDLE_W(IDLE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_keep(cfg_keep), .cfg_words(cfg_words), .cfg_frames(cfg_frames), .cfg_idle(cfg_idle),
    .tick(tick), .run(run), .busy(busy), .cs_n(adc_cs_n), .sclk(adc_sclk),
    .rise_evt(rise_evt), .word_last(word_last), .bit_idx(bit_idx), .keep_q(keep_q)
  );

  sard_capture u_cap (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .word_last(word_last),
    .bit_idx(bit_idx), .keep_q(keep_q), .dout(adc_dout),
    .res_data(res_data), .res_valid(res_valid), .res_partial(res_partial),
    .res_ferr(res_frame_err)
  );
endmodule

// File: tb/sard_ctrl_bench.sv
`timescale 1ns/100ps
module sard_ctrl_bench;
  localparam int HALF = 8;
  localparam int HP_NS = HALF * 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] cfg_keep = 4'd12, cfg_words = 4'd1, cfg_frames = 4'd1;
  logic [7:0] cfg_idle = 8'd0;
  logic       adc_dout = 1'b0;
  logic       adc_cs_n, adc_sclk, busy, res_valid, res_partial, res_frame_err;
  logic [11:0] res_data;

  always #2.5 clk = ~clk;

  sard_ctrl #(.HALF_DIV(HALF)) u_sard_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_keep(cfg_keep), .cfg_words(cfg_words),
    .cfg_frames(cfg_frames), .cfg_idle(cfg_idle), .adc_dout(adc_dout),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .busy(busy), .res_data(res_data),
    .res_valid(res_valid), .res_partial(res_partial), .res_frame_err(res_frame_err)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] gen(input int n);
    case (n % 6)
      0: return 12'h7FF;
      1: return 12'h800;
      2: return 12'h000;
      3: return 12'hFFF;
      default: return 12'((n * 709 + 19) & 12'hFFF);
    endcase
  endfunction

  // converter model
  logic [11:0] sent [0:1023];
  logic [11:0] cur = '0;
  int  conv_idx = 0, fall_k = 0;
  bit  inject = 0;

  always @(negedge adc_cs_n) fall_k = 0;

  always @(negedge adc_sclk) if (!adc_cs_n) begin
    int pos;
    fall_k++;
    pos = (fall_k - 1) % 16 + 1;
    if (pos == 1) begin
      cur = gen(conv_idx);
      sent[conv_idx % 1024] = cur;
      conv_idx++;
    end
    if (pos <= 4) adc_dout = inject && (pos == 2);
    else          adc_dout = cur[16 - pos];
  end

  // expectations of the running test
  int  exp_keep = 12, exp_idle = 0, exp_rises = 16;
  bit  in_run = 0, gap_armed = 0;
  int  rx_idx = 0, frames_seen = 0, rises = 0;
  longint t_edge = 0, t_rise = 0;

  always @(negedge clk) if (res_valid) begin
    logic [11:0] e;
    e = (sent[rx_idx % 1024] >> (12 - exp_keep)) << (12 - exp_keep);
    chk(res_data == e, (exp_keep < 12) ? "R5" : "R3", "result", res_data, e);
    chk(res_partial == (exp_keep < 12), "R5", "partial", res_partial, exp_keep < 12);
    chk(res_frame_err == inject, "R6", "frame_err", res_frame_err, inject);
    rx_idx++;
  end

  always @(negedge adc_cs_n) if (in_run) begin
    chk(adc_sclk === 1'b1, "R2", "sclk at cs fall", adc_sclk, 1);
    if (gap_armed)
      chk(($time - t_rise) == (exp_idle + 1) * HP_NS, "R7", "cs high gap ns",
          $time - t_rise, (exp_idle + 1) * HP_NS);
    t_edge = $time;
    rises = 0;
  end

  always @(adc_sclk) if (in_run) begin
    if (!adc_cs_n) begin
      chk(($time - t_edge) == HP_NS, "R2", "sclk half period ns", $time - t_edge, HP_NS);
      t_edge = $time;
    end else begin
      chk(1'b0, "R7", "sclk moved with cs high", adc_sclk, 1);
    end
  end

  always @(posedge adc_sclk) if (in_run && !adc_cs_n) rises++;

  always @(posedge adc_cs_n) if (in_run) begin
    chk(rises == exp_rises, (exp_keep < 12) ? "R5" : "R4", "rising edges in frame",
        rises, exp_rises);
    frames_seen++;
    t_rise = $time;
    gap_armed = 1;
    adc_dout = 1'b0;
  end

  task automatic do_run(input int k, input int w, input int f, input int idle,
                        input bit inj, input bit poke);
    int kn, wn, fn, base;
    kn = (k == 0 || k > 12) ? 12 : k;
    wn = (kn < 12 || w == 0) ? 1 : w;
    fn = (f == 0) ? 1 : f;
    @(negedge clk);
    exp_keep = kn; exp_idle = idle; inject = inj;
    exp_rises = (kn < 12) ? 4 + kn : 16 * wn;
    base = rx_idx; frames_seen = 0; gap_armed = 0; in_run = 1;
    cfg_keep = 4'(k); cfg_words = 4'(w); cfg_frames = 4'(f); cfg_idle = 8'(idle);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (100) @(negedge clk);
      // R8: extra start while busy; R9: config changes mid-run
      start = 1'b1; cfg_keep = 4'd5; cfg_words = 4'd7; cfg_frames = 4'd9; cfg_idle = 8'd1;
      @(negedge clk) start = 1'b0;
    end
    while (busy) @(negedge clk);
    in_run = 0;
    chk(frames_seen == fn, poke ? "R8" : "R7", "frames per run", frames_seen, fn);
    chk(rx_idx - base == fn * wn, poke ? "R9" : "R4", "results per run",
        rx_idx - base, fn * wn);
    chk(adc_cs_n && adc_sclk && !res_valid, "R1", "idle lines after run",
        {adc_cs_n, adc_sclk, res_valid}, 3'b110);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(adc_cs_n === 1'b1 && adc_sclk === 1'b1 && busy === 1'b0 && res_valid === 1'b0,
        "R1", "reset state", {adc_cs_n, adc_sclk, busy, res_valid}, 4'b1100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && adc_cs_n, "R1", "idle after reset", {busy, adc_cs_n}, 2'b01);
    do_run(12, 1, 1, 0, 0, 0);          // R3 single
    do_run(12, 3, 2, 3, 0, 0);          // R4 continuous
    for (int k = 1; k <= 11; k++)
      do_run(k, 3, 2, k, 0, 0);         // R5 short cycling
    do_run(12, 2, 3, 5, 1, 0);          // R6 null-bit error
    do_run(6, 1, 1, 0, 1, 0);           // R6 with partial
    do_run(0, 0, 0, 2, 0, 0);           // R4/R7 zero configuration
    do_run(14, 4, 1, 0, 0, 0);          // R5 out-of-range keep
    do_run(12, 2, 2, 4, 0, 1);          // R8 R9
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule